// File: doc/BRIEF.md
# I2C Interrupt and Wait Timing Controller

This block decides, byte by byte, when an I2C controller interrupts its processor and when it stretches the clock by holding SCL low. It works in both master and slave roles. It runs on a system clock and synchronizes the bus lines. It watches for START, repeated START and STOP. It counts the clock pulses of each byte, captures the address byte and compares it with a programmed slave address. It also recognizes extension codes.

The interrupt point depends on several things: whether the byte is an address or data, the role, whether the address matched, and whether the address is an extension code. A mode bit moves the data-byte interrupt from the 8th to the 9th clock. Once a wait begins, SCL stays held until software pulses the release input. On an address match the block drives an acknowledge in the 9th clock.

Top module: `i2c_irq_wait_ctl`

## Requirements
- R1: The interrupt and the start of a wait occur only after a falling edge of SCL. START or repeated START (SDA falling while SCL is high) resets the per-byte pulse count. Each SCL rising edge advances it, 1 to 9, for every byte.
- R2: For data bytes in either role, `nine_mode`=0 puts the interrupt and wait at the fall of clock 8, and `nine_mode`=1 puts them at the fall of clock 9.
- R3: In master role the address byte always interrupts and waits at the fall of clock 9, whatever `nine_mode` is.
- R4: In slave role, an address byte whose upper seven bits equal `own_addr` interrupts and waits at the fall of clock 9, whatever `nine_mode` is.
- R5: On a slave address match, `ack_drive` is high during clock 9 even with `ack_en`=0. During a data byte, `ack_drive` is high in clock 9 only when `ack_en`=1.
- R6: A slave address byte whose upper four bits are 0000 or 1111 is an extension code. It interrupts and waits at the fall of clock 8.
- R7: In slave role, an address that neither matches nor is an extension code, received after a plain START, raises no interrupt and no wait, for that byte or for the data bytes after it.
- R8: After a repeated START, a slave address that neither matches nor is an extension code interrupts at the fall of clock 9 without entering a wait.
- R9: A STOP (SDA rising while SCL is high) drops any pending wait and returns the block to idle.
- R10: A pulse on `wait_release` drops `scl_hold` at the next clock edge.
- R11: `irq` is a pulse exactly one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| is_master | input | 1 | 1 selects the master role |
| nine_mode | input | 1 | Data-byte interrupt at clock 9 (1) or clock 8 (0) |
| ack_en | input | 1 | Acknowledge enable for data bytes |
| own_addr | input | ADDR_W | Programmed slave address |
| wait_release | input | 1 | Software pulse that ends a wait |
| irq | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Hold SCL low (wait) |
| ack_drive | output | 1 | Drive SDA low for acknowledge |

## Verification
Four properties are checked on every cycle: the interrupt is one cycle wide, a wait never begins without an interrupt in the same cycle, release and STOP clear the hold at once, and the interrupt only comes while synchronized SCL is low. The placement of the interrupt within the byte can only be shown by the directed scenarios, because it depends on the role, the phase, the address compare, extension codes, repeated starts and the mode bit. The same holds for the acknowledge window.

// File: rtl/i2c_irq_wait_ctl.sv
module i2c_irq_wait_ctl #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              is_master,
  input  logic              nine_mode,
  input  logic              ack_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              wait_release,
  output logic              irq,
  output logic              scl_hold,
  output logic              ack_drive
);
  localparam int BYTE_W = 8;
  localparam int LAST = BYTE_W + 1;
  localparam int CW = $clog2(LAST + 1);

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  logic busy, restart, addr_ph, active, ack_win;
  logic [CW-1:0] cnt;
  logic [BYTE_W-1:0] sh;

  wire match = sh[BYTE_W-1 -: ADDR_W] == own_addr;
  wire ext = (sh[BYTE_W-1 -: 4] == 4'h0) || (sh[BYTE_W-1 -: 4] == 4'hF);
  wire at8 = scl_fall && cnt == CW'(BYTE_W);
  wire at9 = scl_fall && cnt == CW'(LAST);
  wire ack_ok = addr_ph ? (!is_master && match) : (ack_en && active);

  logic fire, stall;
  always_comb begin
    fire = 1'b0;
    stall = 1'b0;
    if (busy) begin
      if (addr_ph) begin
        if (is_master) begin fire = at9; stall = at9; end
        else if (ext) begin fire = at8; stall = at8; end
        else if (match) begin fire = at9; stall = at9; end
        else if (restart) fire = at9;
      end else if (active) begin
        fire = nine_mode ? at9 : at8;
        stall = fire;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; restart <= 1'b0; addr_ph <= 1'b0; active <= 1'b0;
      ack_win <= 1'b0; cnt <= '0; sh <= '0;
    end else if (start_ev) begin
      busy <= 1'b1; restart <= busy; addr_ph <= 1'b1; active <= 1'b0;
      ack_win <= 1'b0; cnt <= '0;
    end else if (stop_ev) begin
      busy <= 1'b0; restart <= 1'b0; addr_ph <= 1'b0; active <= 1'b0;
      ack_win <= 1'b0; cnt <= '0;
    end else begin
      if (scl_rise && busy) begin
        cnt <= (cnt == CW'(LAST)) ? CW'(1) : cnt + CW'(1);
        if (cnt == CW'(LAST)) addr_ph <= 1'b0;
        if (addr_ph && cnt < CW'(BYTE_W)) sh <= {sh[BYTE_W-2:0], sda_s};
      end
      if (at9 && addr_ph) active <= is_master | match | ext;
      if (at8 && busy && ack_ok) ack_win <= 1'b1;
      else if (at9) ack_win <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq <= 1'b0; scl_hold <= 1'b0;
    end else begin
      irq <= fire;
      if (stop_ev || wait_release) scl_hold <= 1'b0;
      else if (stall) scl_hold <= 1'b1;
    end

  assign ack_drive = ack_win;

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !scl_s);
  assert_hold_with_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> irq);
  assert_release_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_release |=> !scl_hold);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!scl_hold && !irq && !ack_drive));
endmodule

// File: tb/sim_i2c_irq_wait_ctl.sv
module sim_i2c_irq_wait_ctl;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, scl = 1, sda = 1;
  logic is_master = 0, nine_mode = 0, ack_en = 0, rel = 0;
  logic [6:0] own = 7'h50;
  logic irq, hold, ack;
  int checks = 0, errors = 0, cur_bit = 0, rel_bad = 0;
  logic [9:0] irq_mask;

  always #5 clk = ~clk;

  i2c_irq_wait_ctl u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .is_master(is_master), .nine_mode(nine_mode), .ack_en(ack_en), .own_addr(own),
    .wait_release(rel), .irq(irq), .scl_hold(hold), .ack_drive(ack));

  always @(negedge clk) if (irq) irq_mask[cur_bit] = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    sda = 1; cyc(H); scl = 1; cyc(H); sda = 0; cyc(H); scl = 0; cyc(H);
  endtask

  task automatic stop_c();
    sda = 0; cyc(H); scl = 1; cyc(H); sda = 1; cyc(H);
  endtask

  task automatic xfer(input logic [7:0] d, input bit do_rel,
                      output logic [9:0] im, output logic [9:0] hm, output bit ak);
    irq_mask = '0; hm = '0; ak = 0;
    for (int k = 1; k <= 9; k++) begin
      sda = (k <= 8) ? d[8-k] : 1'b1;
      cyc(H); scl = 1; cyc(H);
      if (k == 9) ak = ack;
      scl = 0; cur_bit = k; cyc(6);
      hm[k] = hold;
      if (hold && do_rel) begin
        rel = 1; @(negedge clk); rel = 0;
        if (hold) rel_bad++;
      end
      cyc(H);
    end
    im = irq_mask;
  endtask

  task automatic t_reset();
    chk("R1 reset irq", irq, 0);
    chk("R9 reset hold", hold, 0);
    chk("R5 reset ack", ack, 0);
  endtask

  task automatic t_slave_match();
    logic [9:0] im, hm; bit ak;
    is_master = 0; nine_mode = 0; ack_en = 0;
    start_c();
    xfer({own, 1'b0}, 1, im, hm, ak);
    chk("R4 match irq@9", im, 10'b1000000000);
    chk("R4 match hold@9", hm, 10'b1000000000);
    chk("R5 ack without ack_en", ak, 1);
    xfer(8'h3C, 1, im, hm, ak);
    chk("R2 data mode0 irq@8", im, 10'b0100000000);
    chk("R2 data mode0 hold@8", hm, 10'b0100000000);
    chk("R5 data no ack", ak, 0);
    nine_mode = 1; ack_en = 1;
    xfer(8'hC3, 1, im, hm, ak);
    chk("R2 data mode1 irq@9", im, 10'b1000000000);
    chk("R5 data ack with ack_en", ak, 1);
    stop_c();
  endtask

  task automatic t_mismatch();
    logic [9:0] im, hm; bit ak;
    is_master = 0; nine_mode = 0; ack_en = 1;
    start_c();
    xfer(8'h66, 1, im, hm, ak);
    chk("R7 mismatch irq", im, 0);
    chk("R7 mismatch hold", hm, 0);
    chk("R7 mismatch ack", ak, 0);
    xfer(8'h12, 1, im, hm, ak);
    chk("R7 unaddressed data irq", im, 0);
    stop_c();
  endtask

  task automatic t_ext();
    logic [9:0] im, hm; bit ak;
    is_master = 0; nine_mode = 1; ack_en = 0;
    start_c();
    xfer(8'h00, 1, im, hm, ak);
    chk("R6 ext 0000 irq@8", im, 10'b0100000000);
    chk("R6 ext 0000 hold@8", hm, 10'b0100000000);
    stop_c();
    start_c();
    xfer(8'hF2, 1, im, hm, ak);
    chk("R6 ext 1111 irq@8", im, 10'b0100000000);
    xfer(8'h55, 1, im, hm, ak);
    chk("R2 ext data mode1 irq@9", im, 10'b1000000000);
    stop_c();
  endtask

  task automatic t_restart();
    logic [9:0] im, hm; bit ak;
    is_master = 0; nine_mode = 0;
    start_c();
    xfer({own, 1'b1}, 1, im, hm, ak);
    xfer(8'hA5, 1, im, hm, ak);
    start_c();
    xfer(8'h66, 1, im, hm, ak);
    chk("R8 restart mismatch irq@9", im, 10'b1000000000);
    chk("R8 restart mismatch no hold", hm, 0);
    stop_c();
  endtask

  task automatic t_master();
    logic [9:0] im, hm; bit ak;
    is_master = 1; nine_mode = 0; ack_en = 0;
    start_c();
    xfer(8'h24, 1, im, hm, ak);
    chk("R3 master addr irq@9", im, 10'b1000000000);
    chk("R3 master addr hold@9", hm, 10'b1000000000);
    xfer(8'h99, 1, im, hm, ak);
    chk("R2 master data mode0 irq@8", im, 10'b0100000000);
    stop_c();
    is_master = 0;
  endtask

  task automatic t_stop();
    logic [9:0] im, hm; bit ak;
    is_master = 0; nine_mode = 0;
    start_c();
    xfer({own, 1'b0}, 0, im, hm, ak);
    chk("R9 hold pending", hold, 1);
    irq_mask = '0;
    stop_c();
    chk("R9 stop drops hold", hold, 0);
    chk("R9 stop no irq", irq_mask, 0);
    chk("R10 release latency", rel_bad, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(4); t_reset(); rst_n = 1; cyc(4);
    t_slave_match();
    t_mismatch();
    t_ext();
    t_restart();
    t_master();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule